// File: doc/BRIEF.md
# Partial-Access General Register File

This block holds eight 32-bit general registers behind two combinational read ports and one clocked write port. Registers 0 to 3 are data registers: a port can address the low byte, the second byte, the low word or the whole register. Registers 4 to 7 are pointer and index registers and accept only word or whole-register access. Every read port returns a full 32-bit value. A narrow operand comes back either zero-filled or sign-filled, as the port's extend-mode input selects.

The operation input selects one of four register-to-register operations. A plain write loads external data into one lane of a register. Zero-extend and sign-extend moves take the operand on read port A and put it, widened, into a wider destination lane. Swap exchanges the operands on the two read ports within one clock edge, using two write lanes for that cycle. An operation whose operand shapes are illegal raises an error flag in the same cycle and leaves every register unchanged. Bits outside an addressed lane are never disturbed.

Top module: `gpr_bank`

## Requirements
- R1: While rst_ni is low, all eight registers read as zero.
- R2: The part select is encoded as follows: 0 is bits 7:0, 1 is bits 15:8, 2 is bits 15:0 and 3 is bits 31:0. The selected part comes back right-aligned. With 1A2B3C4Dh in register 0, parts 0, 1 and 2 read 4Dh, 3Ch and 3C4Dh.
- R3: Reads are combinational. Writes take effect at the rising clock edge. A write of part 0, 1 or 2 changes only that lane, and all other bits of the register keep their value.
- R4: A read with extend-mode 1 fills the bits above the selected part with the part's top bit. Extend-mode 0 fills them with zeros. Word 8100h reads as FFFF8100h or 00008100h, word 0100h reads as 00000100h in either mode, and part 3 is returned unchanged.
- R5: A byte part (0 or 1) on register index 4 to 7 is illegal. On a read port it raises that port's bad flag and returns zero. As the destination or an operand of an operation, it raises op_err_o and nothing is written.
- R6: Operation code 2 (zero-extend) writes the operand on read port A, zero-filled, into the lane given by wr_idx_i and wr_part_i. Operation code 3 (sign-extend) does the same with sign fill.
- R7: An extend operation whose source size (byte < word < double word) is not strictly smaller than the destination size raises op_err_o and writes nothing.
- R8: Operation code 4 (swap) writes the old port-B operand into the port-A lane and the old port-A operand into the port-B lane at one edge. Both lanes are applied even when they lie in the same register. Operands of unequal size raise op_err_o, and nothing is written.
- R9: Operation code 1 writes the low bits of wr_data_i into the selected lane. Code 0 and codes 5 to 7 write nothing and never raise op_err_o.
- R10: Registers 4 to 7 are fully readable and writable through parts 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 none, 1 write, 2 zero-extend, 3 sign-extend, 4 swap) |
| wr_idx_i | input | 3 | Destination register for write and extend |
| wr_part_i | input | 2 | Destination part for write and extend |
| wr_data_i | input | 32 | Data for operation code 1 |
| rd_a_idx_i | input | 3 | Read port A register select (extend source, swap operand A) |
| rd_a_part_i | input | 2 | Read port A part select |
| rd_a_sext_i | input | 1 | Read port A fill mode (1 sign, 0 zero) |
| rd_a_data_o | output | 32 | Read port A data, widened |
| rd_a_bad_o | output | 1 | Read port A illegal byte access |
| rd_b_idx_i | input | 3 | Read port B register select (swap operand B) |
| rd_b_part_i | input | 2 | Read port B part select |
| rd_b_sext_i | input | 1 | Read port B fill mode |
| rd_b_data_o | output | 32 | Read port B data, widened |
| rd_b_bad_o | output | 1 | Read port B illegal byte access |
| op_err_o | output | 1 | Current operation is illegal and will not write |

## Verification
The bench sweeps every register, part and fill mode on both read ports. A design that swapped the byte lanes or skipped the sign fill shows a mismatch there, and so does one that leaked data through an illegal byte access. It writes every lane of every register and then reads back all eight registers, which exposes a merge that clobbers neighbouring bits or writes to the wrong register. It walks extend operations over all source and destination shapes and swap operations over all register pairs. That includes swapping the two bytes of one register, where a design that dropped one of the two write lanes loses a byte. It also issues illegal-size and reserved operations, which must leave every register exactly as it was.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    PART_LB = 2'd0,
    PART_HB = 2'd1,
    PART_W  = 2'd2,
    PART_D  = 2'd3
  } part_e;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_ZEXT  = 3'd2,
    OP_SEXT  = 3'd3,
    OP_SWAP  = 3'd4
  } op_e;

  // size class: byte 0, word 1, double word 2
  function automatic logic [1:0] part_rank(part_e p);
    case (p)
      PART_W:  return 2'd1;
      PART_D:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_byte(part_e p);
    return (p == PART_LB) || (p == PART_HB);
  endfunction
endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][XLEN-1:0] regs_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [1:0]                    part_i,
  input  logic                          sext_i,
  output logic [XLEN-1:0]               raw_o,
  output logic [XLEN-1:0]               data_o,
  output logic                          bad_o
);
  localparam int BW = XLEN / 4;
  localparam int HW = XLEN / 2;
  localparam logic [XLEN-1:0] FILL_B = {{(XLEN-BW){1'b1}}, {BW{1'b0}}};
  localparam logic [XLEN-1:0] FILL_W = {{(XLEN-HW){1'b1}}, {HW{1'b0}}};

  part_e           part;
  logic [XLEN-1:0] sel;
  logic            msb;
  logic [XLEN-1:0] fill;

  assign part  = part_e'(part_i);
  assign sel   = regs_i[idx_i];
  assign bad_o = is_byte(part) && (32'(idx_i) >= NUM_DATA);

  always_comb begin
    raw_o = '0;
    msb   = 1'b0;
    fill  = '0;
    case (part)
      PART_LB: begin
        raw_o = XLEN'(sel[BW-1:0]);
        msb   = sel[BW-1];
        fill  = FILL_B;
      end
      PART_HB: begin
        raw_o = XLEN'(sel[2*BW-1:BW]);
        msb   = sel[2*BW-1];
        fill  = FILL_B;
      end
      PART_W: begin
        raw_o = XLEN'(sel[HW-1:0]);
        msb   = sel[HW-1];
        fill  = FILL_W;
      end
      default: raw_o = sel;
    endcase
  end

  always_comb begin
    if (bad_o)               data_o = '0;
    else if (sext_i && msb)  data_o = raw_o | fill;
    else                     data_o = raw_o;
  end
endmodule

// File: rtl/gpr_op_ctrl.sv
module gpr_op_ctrl
  import gpr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_part_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [1:0]       a_part_i,
  input  logic [XLEN-1:0]  a_raw_i,
  input  logic             a_bad_i,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic [1:0]       b_part_i,
  input  logic [XLEN-1:0]  b_raw_i,
  input  logic             b_bad_i,
  output logic             w0_en_o,
  output logic [IDX_W-1:0] w0_idx_o,
  output logic [1:0]       w0_part_o,
  output logic [XLEN-1:0]  w0_data_o,
  output logic             w1_en_o,
  output logic [IDX_W-1:0] w1_idx_o,
  output logic [1:0]       w1_part_o,
  output logic [XLEN-1:0]  w1_data_o,
  output logic             err_o
);
  localparam int BW = XLEN / 4;
  localparam int HW = XLEN / 2;

  function automatic logic [XLEN-1:0] widen_signed(logic [XLEN-1:0] v, part_e p);
    case (p)
      PART_LB, PART_HB: return v[BW-1] ? (v | {{(XLEN-BW){1'b1}}, {BW{1'b0}}}) : v;
      PART_W:           return v[HW-1] ? (v | {{(XLEN-HW){1'b1}}, {HW{1'b0}}}) : v;
      default:          return v;
    endcase
  endfunction

  part_e wr_part, a_part, b_part;
  logic  dst_bad;

  assign wr_part = part_e'(wr_part_i);
  assign a_part  = part_e'(a_part_i);
  assign b_part  = part_e'(b_part_i);
  assign dst_bad = is_byte(wr_part) && (32'(wr_idx_i) >= NUM_DATA);

  always_comb begin
    err_o     = 1'b0;
    w0_en_o   = 1'b0;
    w0_idx_o  = wr_idx_i;
    w0_part_o = wr_part_i;
    w0_data_o = '0;
    w1_en_o   = 1'b0;
    w1_idx_o  = b_idx_i;
    w1_part_o = b_part_i;
    w1_data_o = a_raw_i;
    case (op_e'(op_i))
      OP_WRITE: begin
        err_o     = dst_bad;
        w0_en_o   = !dst_bad;
        w0_data_o = wr_data_i;
      end
      OP_ZEXT, OP_SEXT: begin
        err_o     = dst_bad || a_bad_i || (part_rank(a_part) >= part_rank(wr_part));
        w0_en_o   = !err_o;
        w0_data_o = (op_e'(op_i) == OP_SEXT) ? widen_signed(a_raw_i, a_part) : a_raw_i;
      end
      OP_SWAP: begin
        err_o     = a_bad_i || b_bad_i || (part_rank(a_part) != part_rank(b_part));
        w0_en_o   = !err_o;
        w0_idx_o  = a_idx_i;
        w0_part_o = a_part_i;
        w0_data_o = b_raw_i;
        w1_en_o   = !err_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          w0_en_i,
  input  logic [IDX_W-1:0]              w0_idx_i,
  input  logic [1:0]                    w0_part_i,
  input  logic [XLEN-1:0]               w0_data_i,
  input  logic                          w1_en_i,
  input  logic [IDX_W-1:0]              w1_idx_i,
  input  logic [1:0]                    w1_part_i,
  input  logic [XLEN-1:0]               w1_data_i,
  output logic [NUM_REGS-1:0][XLEN-1:0] regs_o
);
  localparam int BW = XLEN / 4;
  localparam int HW = XLEN / 2;

  function automatic logic [XLEN-1:0] lane_merge(logic [XLEN-1:0] old, logic [1:0] p,
                                                 logic [XLEN-1:0] d);
    case (part_e'(p))
      PART_LB: return {old[XLEN-1:BW], d[BW-1:0]};
      PART_HB: return {old[XLEN-1:2*BW], d[BW-1:0], old[BW-1:0]};
      PART_W:  return {old[XLEN-1:HW], d[HW-1:0]};
      default: return d;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [XLEN-1:0] q, mid, nxt;
    logic            hit0, hit1;

    assign hit0 = w0_en_i && (w0_idx_i == IDX_W'(g));
    assign hit1 = w1_en_i && (w1_idx_i == IDX_W'(g));

    // lane 1 lands on top of lane 0 so a same-register swap keeps both
    always_comb begin
      mid = hit0 ? lane_merge(q, w0_part_i, w0_data_i) : q;
      nxt = hit1 ? lane_merge(mid, w1_part_i, w1_data_i) : mid;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= nxt;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_part_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [1:0]       rd_a_part_i,
  input  logic             rd_a_sext_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  output logic             rd_a_bad_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic [1:0]       rd_b_part_i,
  input  logic             rd_b_sext_i,
  output logic [XLEN-1:0]  rd_b_data_o,
  output logic             rd_b_bad_o,
  output logic             op_err_o
);
  localparam int NUM_RP = 2;

  logic [NUM_REGS-1:0][XLEN-1:0] regs_q;

  logic [NUM_RP-1:0][IDX_W-1:0] rp_idx;
  logic [NUM_RP-1:0][1:0]       rp_part;
  logic [NUM_RP-1:0]            rp_sext, rp_bad;
  logic [NUM_RP-1:0][XLEN-1:0]  rp_raw, rp_data;

  assign rp_idx  = {rd_b_idx_i, rd_a_idx_i};
  assign rp_part = {rd_b_part_i, rd_a_part_i};
  assign rp_sext = {rd_b_sext_i, rd_a_sext_i};

  for (genvar p = 0; p < NUM_RP; p++) begin : g_rp
    gpr_read_port #(
      .XLEN(XLEN), .NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA)
    ) u_rp (
      .regs_i (regs_q),
      .idx_i  (rp_idx[p]),
      .part_i (rp_part[p]),
      .sext_i (rp_sext[p]),
      .raw_o  (rp_raw[p]),
      .data_o (rp_data[p]),
      .bad_o  (rp_bad[p])
    );
  end

  assign rd_a_data_o = rp_data[0];
  assign rd_b_data_o = rp_data[1];
  assign rd_a_bad_o  = rp_bad[0];
  assign rd_b_bad_o  = rp_bad[1];

  logic             w0_en, w1_en;
  logic [IDX_W-1:0] w0_idx, w1_idx;
  logic [1:0]       w0_part, w1_part;
  logic [XLEN-1:0]  w0_data, w1_data;

  gpr_op_ctrl #(
    .XLEN(XLEN), .NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA)
  ) u_ctrl (
    .op_i      (op_i),
    .wr_idx_i  (wr_idx_i),
    .wr_part_i (wr_part_i),
    .wr_data_i (wr_data_i),
    .a_idx_i   (rd_a_idx_i),
    .a_part_i  (rd_a_part_i),
    .a_raw_i   (rp_raw[0]),
    .a_bad_i   (rp_bad[0]),
    .b_idx_i   (rd_b_idx_i),
    .b_part_i  (rd_b_part_i),
    .b_raw_i   (rp_raw[1]),
    .b_bad_i   (rp_bad[1]),
    .w0_en_o   (w0_en),
    .w0_idx_o  (w0_idx),
    .w0_part_o (w0_part),
    .w0_data_o (w0_data),
    .w1_en_o   (w1_en),
    .w1_idx_o  (w1_idx),
    .w1_part_o (w1_part),
    .w1_data_o (w1_data),
    .err_o     (op_err_o)
  );

  gpr_storage #(
    .XLEN(XLEN), .NUM_REGS(NUM_REGS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .w0_en_i   (w0_en),
    .w0_idx_i  (w0_idx),
    .w0_part_i (w0_part),
    .w0_data_i (w0_data),
    .w1_en_i   (w1_en),
    .w1_idx_i  (w1_idx),
    .w1_part_i (w1_part),
    .w1_data_i (w1_data),
    .regs_o    (regs_q)
  );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk
  import gpr_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NUM_REGS = 8,
  parameter int NUM_DATA = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2:0]                    op_i,
  input logic [IDX_W-1:0]              wr_idx_i,
  input logic [1:0]                    wr_part_i,
  input logic [IDX_W-1:0]              rd_a_idx_i,
  input logic [1:0]                    rd_a_part_i,
  input logic                          rd_a_sext_i,
  input logic [XLEN-1:0]               rd_a_data_o,
  input logic                          rd_a_bad_o,
  input logic [IDX_W-1:0]              rd_b_idx_i,
  input logic [1:0]                    rd_b_part_i,
  input logic                          op_err_o,
  input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);
  localparam int BW = XLEN / 4;
  localparam int HW = XLEN / 2;

  AST_BYTE_PTR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_part_i[1] == 1'b0 && 32'(rd_a_idx_i) >= NUM_DATA) |-> (rd_a_bad_o && rd_a_data_o == '0)); // R5

  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_a_sext_i && rd_a_part_i == PART_W) |-> (rd_a_data_o[XLEN-1:HW] == '0)); // R4

  AST_SIGN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_sext_i && rd_a_part_i == PART_W) |-> (rd_a_data_o[XLEN-1:HW] == {(XLEN-HW){rd_a_data_o[HW-1]}})); // R4

  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_err_o |=> $stable(regs_q)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i > 3'd4) |=> ($stable(regs_q) && !$past(op_err_o))); // R9

  AST_HB_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WRITE && !op_err_o && wr_part_i == PART_HB) |=>
      (regs_q[$past(wr_idx_i)][BW-1:0] == $past(regs_q[wr_idx_i][BW-1:0]) &&
       regs_q[$past(wr_idx_i)][XLEN-1:2*BW] == $past(regs_q[wr_idx_i][XLEN-1:2*BW]))); // R3

  AST_SWAP_DWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SWAP && !op_err_o && rd_a_part_i == PART_D && rd_b_part_i == PART_D) |=>
      (regs_q[$past(rd_a_idx_i)] == $past(regs_q[rd_b_idx_i]) &&
       regs_q[$past(rd_b_idx_i)] == $past(regs_q[rd_a_idx_i]))); // R8
endmodule

bind gpr_bank gpr_bank_chk #(
  .XLEN(XLEN), .NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .wr_idx_i    (wr_idx_i),
  .wr_part_i   (wr_part_i),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_part_i (rd_a_part_i),
  .rd_a_sext_i (rd_a_sext_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_a_bad_o  (rd_a_bad_o),
  .rd_b_idx_i  (rd_b_idx_i),
  .rd_b_part_i (rd_b_part_i),
  .op_err_o    (op_err_o),
  .regs_q      (regs_q)
);

// File: tb/gpr_bank_bench.sv
module gpr_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [2:0]  wr_idx_i = 3'd0;
  logic [1:0]  wr_part_i = 2'd3;
  logic [31:0] wr_data_i = 32'd0;
  logic [2:0]  rd_a_idx_i = 3'd0;
  logic [1:0]  rd_a_part_i = 2'd3;
  logic        rd_a_sext_i = 1'b0;
  logic [31:0] rd_a_data_o;
  logic        rd_a_bad_o;
  logic [2:0]  rd_b_idx_i = 3'd0;
  logic [1:0]  rd_b_part_i = 2'd3;
  logic        rd_b_sext_i = 1'b0;
  logic [31:0] rd_b_data_o;
  logic        rd_b_bad_o;
  logic        op_err_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_r [8];

  always #10 clk_i = ~clk_i;

  gpr_bank u_gpr_bank (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] view(logic [31:0] v, logic [1:0] p, logic sx);
    logic [31:0] n;
    int w;
    case (p)
      2'd0: begin n = v & 32'hFF;          w = 8;  end
      2'd1: begin n = (v >> 8) & 32'hFF;   w = 8;  end
      2'd2: begin n = v & 32'hFFFF;        w = 16; end
      default: return v;
    endcase
    if (sx && n[w-1]) n = n | ~((32'd1 << w) - 32'd1);
    return n;
  endfunction

  function automatic logic [31:0] put(logic [31:0] old, logic [1:0] p, logic [31:0] d);
    logic [31:0] m;
    int sh;
    case (p)
      2'd0: begin m = 32'h0000_00FF; sh = 0; end
      2'd1: begin m = 32'h0000_FF00; sh = 8; end
      2'd2: begin m = 32'h0000_FFFF; sh = 0; end
      default: begin m = 32'hFFFF_FFFF; sh = 0; end
    endcase
    return (old & ~m) | ((d << sh) & m);
  endfunction

  function automatic int rank(logic [1:0] p);
    return (p < 2) ? 0 : int'(p) - 1;
  endfunction

  function automatic logic byte_bad(logic [2:0] idx, logic [1:0] p);
    return (p < 2) && (idx >= 3'd4);
  endfunction

  task automatic check_all(input string tag);
    for (int r = 0; r < 8; r++) begin
      rd_b_idx_i = 3'(r); rd_b_part_i = 2'd3; rd_b_sext_i = 1'b0;
      #1;
      chk(rd_b_data_o == exp_r[r], tag, rd_b_data_o, exp_r[r]);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [2:0] w, input logic [1:0] wp,
                        input logic [31:0] wd, input logic [2:0] a, input logic [1:0] ap,
                        input logic [2:0] b, input logic [1:0] bp, input string tag);
    logic e;
    logic [31:0] va, vb;
    @(negedge clk_i);
    op_i = op; wr_idx_i = w; wr_part_i = wp; wr_data_i = wd;
    rd_a_idx_i = a; rd_a_part_i = ap; rd_a_sext_i = 1'b0;
    rd_b_idx_i = b; rd_b_part_i = bp; rd_b_sext_i = 1'b0;
    case (op)
      3'd1:       e = byte_bad(w, wp);
      3'd2, 3'd3: e = byte_bad(w, wp) || byte_bad(a, ap) || (rank(ap) >= rank(wp));
      3'd4:       e = byte_bad(a, ap) || byte_bad(b, bp) || (rank(ap) != rank(bp));
      default:    e = 1'b0;
    endcase
    #1;
    chk(op_err_o == e, {tag, " err"}, 32'(op_err_o), 32'(e));
    @(posedge clk_i);
    if (!e) begin
      case (op)
        3'd1: exp_r[w] = put(exp_r[w], wp, wd);
        3'd2, 3'd3: exp_r[w] = put(exp_r[w], wp, view(exp_r[a], ap, op == 3'd3));
        3'd4: begin
          va = view(exp_r[a], ap, 1'b0);
          vb = view(exp_r[b], bp, 1'b0);
          exp_r[a] = put(exp_r[a], ap, vb);
          exp_r[b] = put(exp_r[b], bp, va);
        end
        default: ;
      endcase
    end
    @(negedge clk_i);
    op_i = 3'd0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) exp_r[r] = 32'd0;
    repeat (3) @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;

    // full writes to every register, pointer registers included
    for (int r = 0; r < 8; r++)
      run_op(3'd1, 3'(r), 2'd3, 32'h8180_F17F ^ (32'h0123_4567 * r), 3'd0, 2'd3, 3'd0, 2'd3, "R10 R9 dword write");
    run_op(3'd1, 3'd0, 2'd3, 32'h1A2B_3C4D, 3'd0, 2'd3, 3'd0, 2'd3, "R9 write");

    @(negedge clk_i);
    rd_a_idx_i = 3'd0; rd_a_sext_i = 1'b0;
    rd_a_part_i = 2'd0; #1 chk(rd_a_data_o == 32'h4D, "R2 low byte", rd_a_data_o, 32'h4D);
    rd_a_part_i = 2'd1; #1 chk(rd_a_data_o == 32'h3C, "R2 high byte", rd_a_data_o, 32'h3C);
    rd_a_part_i = 2'd2; #1 chk(rd_a_data_o == 32'h3C4D, "R2 word", rd_a_data_o, 32'h3C4D);

    // read sweep on both ports
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < 4; p++)
        for (int s = 0; s < 2; s++) begin
          logic bad;
          logic [31:0] ev;
          @(negedge clk_i);
          rd_a_idx_i = 3'(r); rd_a_part_i = 2'(p); rd_a_sext_i = 1'(s);
          rd_b_idx_i = 3'(r); rd_b_part_i = 2'(p); rd_b_sext_i = 1'(s);
          bad = byte_bad(3'(r), 2'(p));
          ev = bad ? 32'd0 : view(exp_r[r], 2'(p), 1'(s));
          #1;
          chk(rd_a_data_o == ev, "R2 R4 R5 port A read", rd_a_data_o, ev);
          chk(rd_b_data_o == ev, "R2 R4 R5 port B read", rd_b_data_o, ev);
          chk(rd_a_bad_o == bad && rd_b_bad_o == bad, "R5 bad flag", 32'({rd_a_bad_o, rd_b_bad_o}), 32'({bad, bad}));
        end

    // lane writes into every register and part
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < 4; p++)
        run_op(3'd1, 3'(r), 2'(p), 32'hC3A5_5A00 + 32'(r * 16 + p * 37), 3'd0, 2'd3, 3'd0, 2'd3, "R3 R5 lane write");

    // named extension cases
    run_op(3'd1, 3'd3, 2'd3, 32'h0000_8100, 3'd0, 2'd3, 3'd0, 2'd3, "R9 setup");
    run_op(3'd3, 3'd1, 2'd3, 32'd0, 3'd3, 2'd2, 3'd0, 2'd3, "R6 sign extend");
    chk(exp_r[1] == 32'hFFFF_8100, "R6 model sext", exp_r[1], 32'hFFFF_8100);
    run_op(3'd2, 3'd2, 2'd3, 32'd0, 3'd3, 2'd2, 3'd0, 2'd3, "R6 zero extend");
    chk(exp_r[2] == 32'h0000_8100, "R6 model zext", exp_r[2], 32'h0000_8100);
    run_op(3'd1, 3'd3, 2'd2, 32'h0000_0100, 3'd0, 2'd3, 3'd0, 2'd3, "R9 setup");
    run_op(3'd3, 3'd4, 2'd3, 32'd0, 3'd3, 2'd2, 3'd0, 2'd3, "R6 R10 sign extend positive");
    @(negedge clk_i);
    rd_a_idx_i = 3'd4; rd_a_part_i = 2'd3; #1;
    chk(rd_a_data_o == 32'h0000_0100, "R4 positive word", rd_a_data_o, 32'h0000_0100);
    rd_a_idx_i = 3'd1; #1;
    chk(rd_a_data_o == 32'hFFFF_8100, "R4 negative word", rd_a_data_o, 32'hFFFF_8100);
    run_op(3'd2, 3'd1, 2'd2, 32'd0, 3'd2, 2'd2, 3'd0, 2'd3, "R7 equal size extend");

    // extend sweep over all shapes
    for (int a = 0; a < 8; a++)
      for (int ap = 0; ap < 4; ap++)
        for (int wp = 0; wp < 4; wp++)
          for (int op = 2; op < 4; op++)
            run_op(3'(op), 3'((a + 3) % 8), 2'(wp), 32'd0, 3'(a), 2'(ap), 3'd0, 2'd3, "R6 R7 extend sweep");

    // refresh values, then swap sweep
    for (int r = 0; r < 8; r++)
      run_op(3'd1, 3'(r), 2'd3, 32'h9E37_79B9 * (r + 1), 3'd0, 2'd3, 3'd0, 2'd3, "R9 refresh");
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int k = 0; k < 5; k++) begin
          logic [1:0] ap, bp;
          case (k)
            0: begin ap = 2'd3; bp = 2'd3; end
            1: begin ap = 2'd2; bp = 2'd2; end
            2: begin ap = 2'd0; bp = 2'd1; end
            3: begin ap = 2'd1; bp = 2'd0; end
            default: begin ap = 2'd0; bp = 2'd2; end
          endcase
          run_op(3'd4, 3'd0, 2'd3, 32'd0, 3'(a), ap, 3'(b), bp, "R8 swap sweep");
        end
    // bytes of one register exchanged
    run_op(3'd1, 3'd2, 2'd3, 32'h1122_3344, 3'd0, 2'd3, 3'd0, 2'd3, "R9 setup");
    run_op(3'd4, 3'd0, 2'd3, 32'd0, 3'd2, 2'd0, 3'd2, 2'd1, "R8 same register bytes");
    chk(exp_r[2] == 32'h1122_4433, "R8 model bytes", exp_r[2], 32'h1122_4433);

    // idle and reserved codes
    for (int op = 5; op < 8; op++)
      run_op(3'(op), 3'd0, 2'd3, 32'hDEAD_BEEF, 3'd1, 2'd0, 3'd2, 2'd3, "R9 reserved op");
    run_op(3'd0, 3'd5, 2'd0, 32'hDEAD_BEEF, 3'd6, 2'd0, 3'd7, 2'd3, "R9 idle op");

    // asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int r = 0; r < 8; r++) exp_r[r] = 32'd0;
    #2;
    check_all("R1 reset mid-run");
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule